// File: doc/BRIEF.md
# Modular-Exponentiation Accelerator Control Register File

This block is the host-facing register file of a modular-exponentiation engine. A host on a simple 32-bit bus programs the operand source address, the transfer length in bytes, the exponent and modulus lengths in bits and the operation mode. It then launches the engine by writing the start and operand-source bits together. The engine reports progress with single-cycle ready and complete pulses. These are latched as status bits and cleared by writing ones back. An operation is finished only when both are latched. Each status bit can be enabled onto a single interrupt line.

Once the result is ready, the host clears the launch register and sets a grant bit. The block then hands the engine's internal scratch SRAM to the bus, but only while the engine reports itself idle. Reads in the SRAM window (upper half of the address space) return scratch words while the grant holds and zero otherwise. Clearing the grant bit returns the SRAM to the engine. The arithmetic datapath and the DMA mover sit outside this block.

Top module: `mexp_csr`

## Requirements
- R1: After reset every register is zero, so eng_start, eng_use_dma, eng_mode, dma_src_addr, dma_len, exp_bits, mod_bits, irq, op_done and sram_host_sel are low, and every read returns zero.
- R2: Offset 0x04C holds the 32-bit operand source address. Offset 0x050 holds the byte count in bits 15:0, and its upper bits read zero. Offset 0x058 holds the exponent bit length in bits 31:16 and the modulus bit length in bits 15:0. Each field drives its output from the cycle after the write.
- R3: A write to offset 0x000 records bit 1 as eng_use_dma. If bit 0 is one and eng_busy is low, eng_start is high for exactly the next cycle and bit 0 reads back as one. Writing bit 0 as zero clears that readback.
- R4: A write to offset 0x000 with bit 0 set while eng_busy is high produces no eng_start pulse and leaves the bit 0 readback unchanged.
- R5: Offset 0x048 bits 5:4 hold the operation mode driven on eng_mode: 3 selects RSA and 2 selects ECC.
- R6: Status at offset 0x3FC has bit 2 = ready and bit 1 = complete. A cycle-long eng_ready or eng_done pulse sets its bit. Writing a one to a bit clears it. A pulse in the same cycle as the clearing write leaves the bit set.
- R7: Enable at offset 0x3F8 uses the same bit positions as status. irq is high whenever some status bit and its enable bit are both set.
- R8: op_done is high exactly when both the ready and complete status bits are set.
- R9: Offset 0x048 bit 8 requests host access to the scratch SRAM. sram_host_sel is high only while that bit is set and eng_busy is low. A read with address bit 12 set returns sram_rdata for word sram_addr = bus_addr[11:2] under that grant and zero otherwise. Writes there change nothing.
- R10: Reads return zero when bus_valid is low, during writes, and at any other offset, including 0x044 and unaligned byte addresses. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_busy | input | 1 | Engine is running |
| eng_ready | input | 1 | Single-cycle ready event |
| eng_done | input | 1 | Single-cycle complete event |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_use_dma | output | 1 | Operands come by DMA |
| eng_mode | output | 2 | Operation mode |
| dma_src_addr | output | 32 | Operand source address |
| dma_len | output | 16 | Transfer length in bytes |
| exp_bits | output | 16 | Exponent length in bits |
| mod_bits | output | 16 | Modulus length in bits |
| irq | output | 1 | Interrupt request |
| op_done | output | 1 | Ready and complete both latched |
| sram_host_sel | output | 1 | Scratch SRAM owned by bus |
| sram_addr | output | 10 | Scratch word index |
| sram_rdata | input | 32 | Scratch read data |

## Verification
The bench builds the block with ADDR_W = 13 and SRAM_AW = 10. This places the scratch window at byte 0x1000 and the whole register space below it. These defaults let a single 13-bit address reach both unaligned register offsets and the far end of the SRAM window. The bench's scratch model returns a value derived from the word index, so reads in the window also check the address slice. With eng_busy driven freely, the bench can hold the grant bit set while the engine runs, and it can line up event pulses against clearing writes in the same cycle.

// File: rtl/mexp_csr_pkg.sv
package mexp_csr_pkg;
  localparam int unsigned OFF_CTRL = 32'h000;
  localparam int unsigned OFF_CFG  = 32'h048;
  localparam int unsigned OFF_SRC  = 32'h04C;
  localparam int unsigned OFF_LEN  = 32'h050;
  localparam int unsigned OFF_BITS = 32'h058;
  localparam int unsigned OFF_IEN  = 32'h3F8;
  localparam int unsigned OFF_ISTS = 32'h3FC;

  localparam int unsigned FIELD_W = 16;
  localparam int unsigned EVT_N   = 2;   // index 0 = complete, 1 = ready
  localparam int unsigned EVT_LSB = 1;   // events occupy bits 2:1

  typedef struct packed {
    logic ctrl;
    logic cfg;
    logic src;
    logic len;
    logic bits;
    logic ien;
    logic ists;
    logic sram;
  } csr_sel_t;

  function automatic logic [31:0] pack_cfg(input logic [1:0] mode, input logic grant);
    logic [31:0] v;
    v = '0;
    v[5:4] = mode;
    v[8]   = grant;
    return v;
  endfunction

  function automatic logic [31:0] pack_evt(input logic [EVT_N-1:0] e);
    logic [31:0] v;
    v = '0;
    v[EVT_LSB +: EVT_N] = e;
    return v;
  endfunction
endpackage

// File: rtl/mexp_csr_decode.sv
module mexp_csr_decode
  import mexp_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_t          sel
);
  localparam int unsigned OW = ADDR_W - 1;
  logic [OW-1:0] off;

  assign off = addr[OW-1:0];

  always_comb begin
    sel = '0;
    if (addr[ADDR_W-1]) begin
      sel.sram = 1'b1;
    end else begin
      sel.ctrl = (off == OW'(OFF_CTRL));
      sel.cfg  = (off == OW'(OFF_CFG));
      sel.src  = (off == OW'(OFF_SRC));
      sel.len  = (off == OW'(OFF_LEN));
      sel.bits = (off == OW'(OFF_BITS));
      sel.ien  = (off == OW'(OFF_IEN));
      sel.ists = (off == OW'(OFF_ISTS));
    end
  end
endmodule

// File: rtl/mexp_csr_irq.sv
module mexp_csr_irq
  import mexp_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_pulse,
  input  logic             en_we,
  input  logic             sts_we,
  input  logic [EVT_N-1:0] wdata_evt,
  output logic [EVT_N-1:0] en,
  output logic [EVT_N-1:0] sts,
  output logic             irq,
  output logic             all_set
);
  always_ff @(posedge clk) begin
    if (!rst_n)     en <= '0;
    else if (en_we) en <= wdata_evt;
  end

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n)                         sts[i] <= 1'b0;
      else if (evt_pulse[i])              sts[i] <= 1'b1;
      else if (sts_we && wdata_evt[i])    sts[i] <= 1'b0;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[i] |=> sts[i]);
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && wdata_evt[i] && !evt_pulse[i]) |=> !sts[i]);
  end

  assign irq     = |(sts & en);
  assign all_set = &sts;

  assert_irq_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|en));
endmodule

// File: rtl/mexp_csr_sram_arb.sv
module mexp_csr_sram_arb #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              grant_req,
  input  logic              eng_busy,
  input  logic              win_rd,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              host_sel,
  output logic [DATA_W-1:0] win_data
);
  assign host_sel = grant_req && !eng_busy;
  assign win_data = (win_rd && host_sel) ? sram_rdata : '0;
endmodule

// File: rtl/mexp_csr.sv
module mexp_csr
  import mexp_csr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned SRAM_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               eng_busy,
  input  logic               eng_ready,
  input  logic               eng_done,
  output logic               eng_start,
  output logic               eng_use_dma,
  output logic [1:0]         eng_mode,
  output logic [31:0]        dma_src_addr,
  output logic [FIELD_W-1:0] dma_len,
  output logic [FIELD_W-1:0] exp_bits,
  output logic [FIELD_W-1:0] mod_bits,
  output logic               irq,
  output logic               op_done,
  output logic               sram_host_sel,
  output logic [SRAM_AW-1:0] sram_addr,
  input  logic [31:0]        sram_rdata
);
  localparam int unsigned WIN_BIT = ADDR_W - 1;

  csr_sel_t         sel;
  logic             wr, rd;
  logic             start_accept;
  logic             start_flag;
  logic             grant_req;
  logic [EVT_N-1:0] evt_en, evt_sts;
  logic [31:0]      win_data;
  logic [31:0]      reg_data;

  assign wr = bus_valid && bus_we;
  assign rd = bus_valid && !bus_we;

  mexp_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  // launch accepted only with the engine idle
  assign start_accept = wr && sel.ctrl && bus_wdata[0] && !eng_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_start    <= 1'b0;
      start_flag   <= 1'b0;
      eng_use_dma  <= 1'b0;
      eng_mode     <= '0;
      grant_req    <= 1'b0;
      dma_src_addr <= '0;
      dma_len      <= '0;
      exp_bits     <= '0;
      mod_bits     <= '0;
    end else begin
      eng_start <= start_accept;
      if (wr && sel.ctrl) begin
        eng_use_dma <= bus_wdata[1];
        if (start_accept)      start_flag <= 1'b1;
        else if (!bus_wdata[0]) start_flag <= 1'b0;
      end
      if (wr && sel.cfg) begin
        eng_mode  <= bus_wdata[5:4];
        grant_req <= bus_wdata[8];
      end
      if (wr && sel.src)  dma_src_addr <= bus_wdata;
      if (wr && sel.len)  dma_len      <= bus_wdata[FIELD_W-1:0];
      if (wr && sel.bits) begin
        exp_bits <= bus_wdata[31:16];
        mod_bits <= bus_wdata[FIELD_W-1:0];
      end
    end
  end

  mexp_csr_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse ({eng_ready, eng_done}),
    .en_we     (wr && sel.ien),
    .sts_we    (wr && sel.ists),
    .wdata_evt (bus_wdata[EVT_LSB +: EVT_N]),
    .en        (evt_en),
    .sts       (evt_sts),
    .irq       (irq),
    .all_set   (op_done)
  );

  assign sram_addr = bus_addr[SRAM_AW+1:2];

  mexp_csr_sram_arb #(.DATA_W(32)) u_arb (
    .grant_req  (grant_req),
    .eng_busy   (eng_busy),
    .win_rd     (rd && sel.sram),
    .sram_rdata (sram_rdata),
    .host_sel   (sram_host_sel),
    .win_data   (win_data)
  );

  always_comb begin
    reg_data = '0;
    unique case (1'b1)
      sel.ctrl: reg_data = {30'd0, eng_use_dma, start_flag};
      sel.cfg:  reg_data = pack_cfg(eng_mode, grant_req);
      sel.src:  reg_data = dma_src_addr;
      sel.len:  reg_data = {16'd0, dma_len};
      sel.bits: reg_data = {exp_bits, mod_bits};
      sel.ien:  reg_data = pack_evt(evt_en);
      sel.ists: reg_data = pack_evt(evt_sts);
      sel.sram: reg_data = win_data;
      default:  reg_data = '0;
    endcase
  end

  assign bus_rdata = rd ? reg_data : '0;

  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(!eng_busy));
  assert_sram_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr[WIN_BIT] && eng_busy) |-> (bus_rdata == '0));
endmodule

// File: tb/mexp_csr_bench.sv
module mexp_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_busy = 1'b0, eng_ready = 1'b0, eng_done = 1'b0;
  logic        eng_start, eng_use_dma, irq, op_done, sram_host_sel;
  logic [1:0]  eng_mode;
  logic [31:0] dma_src_addr, sram_rdata;
  logic [15:0] dma_len, exp_bits, mod_bits;
  logic [9:0]  sram_addr;

  always #2 clk = ~clk;

  assign sram_rdata = 32'h5A00_0000 ^ {22'd0, sram_addr};

  mexp_csr u_mexp_csr (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_ready(eng_ready), .eng_done(eng_done),
    .eng_start(eng_start), .eng_use_dma(eng_use_dma), .eng_mode(eng_mode),
    .dma_src_addr(dma_src_addr), .dma_len(dma_len), .exp_bits(exp_bits),
    .mod_bits(mod_bits), .irq(irq), .op_done(op_done),
    .sram_host_sel(sram_host_sel), .sram_addr(sram_addr), .sram_rdata(sram_rdata)
  );

  // behavioural reference state
  bit          m_start, m_flag, m_dma, m_grant;
  bit   [1:0]  m_mode;
  bit   [31:0] m_src;
  bit   [15:0] m_len, m_exp, m_mod;
  bit          m_en_rdy, m_en_cmp, m_st_rdy, m_st_cmp;
  int          n_cmp = 0, n_bad = 0;
  bit          in_reset_phase = 1'b1;
  bit          finished = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_flag = 0; m_dma = 0; m_grant = 0; m_mode = 0;
      m_src = 0; m_len = 0; m_exp = 0; m_mod = 0;
      m_en_rdy = 0; m_en_cmp = 0; m_st_rdy = 0; m_st_cmp = 0;
    end else begin
      m_start = 0;
      if (bus_valid && bus_we) begin
        case (bus_addr)
          13'h000: begin
            m_dma = bus_wdata[1];
            if (bus_wdata[0] && !eng_busy) begin m_start = 1; m_flag = 1; end
            else if (!bus_wdata[0]) m_flag = 0;
          end
          13'h048: begin m_mode = bus_wdata[5:4]; m_grant = bus_wdata[8]; end
          13'h04C: m_src = bus_wdata;
          13'h050: m_len = bus_wdata[15:0];
          13'h058: begin m_exp = bus_wdata[31:16]; m_mod = bus_wdata[15:0]; end
          13'h3F8: begin m_en_rdy = bus_wdata[2]; m_en_cmp = bus_wdata[1]; end
          13'h3FC: begin
            if (bus_wdata[2]) m_st_rdy = 0;
            if (bus_wdata[1]) m_st_cmp = 0;
          end
          default: ;
        endcase
      end
      if (eng_ready) m_st_rdy = 1;
      if (eng_done)  m_st_cmp = 1;
    end
  end

  function automatic bit [31:0] exp_read(output string tag);
    bit [31:0] v;
    v = 0;
    tag = "R10";
    if (!(bus_valid && !bus_we)) return 0;
    if (bus_addr >= 13'h1000) begin
      tag = "R9";
      if (m_grant && !eng_busy) v = 32'h5A00_0000 ^ 32'(bus_addr[11:2]);
      return v;
    end
    case (bus_addr)
      13'h000: begin tag = "R3"; v = {30'd0, m_dma, m_flag}; end
      13'h048: begin tag = "R5"; v[5:4] = m_mode; v[8] = m_grant; end
      13'h04C: begin tag = "R2"; v = m_src; end
      13'h050: begin tag = "R2"; v = {16'd0, m_len}; end
      13'h058: begin tag = "R2"; v = {m_exp, m_mod}; end
      13'h3F8: begin tag = "R7"; v = {29'd0, m_en_rdy, m_en_cmp, 1'b0}; end
      13'h3FC: begin tag = "R6"; v = {29'd0, m_st_rdy, m_st_cmp, 1'b0}; end
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", in_reset_phase ? "R1" : tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    string t;
    bit [31:0] e;
    e = exp_read(t);
    chk(t, bus_rdata, e);
    chk("R3", 32'(eng_start), 32'(m_start));
    chk("R3", 32'(eng_use_dma), 32'(m_dma));
    chk("R5", 32'(eng_mode), 32'(m_mode));
    chk("R2", dma_src_addr, m_src);
    chk("R2", {dma_len, mod_bits}, {m_len, m_mod});
    chk("R2", 32'(exp_bits), 32'(m_exp));
    chk("R7", 32'(irq), 32'((m_st_rdy && m_en_rdy) || (m_st_cmp && m_en_cmp)));
    chk("R8", 32'(op_done), 32'(m_st_rdy && m_st_cmp));
    chk("R9", 32'(sram_host_sel), 32'(m_grant && !eng_busy));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [12:0] a);
    bus_valid = 1; bus_we = 0; bus_addr = a;
    tick();
    bus_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset values on every output and register
    idle(2);
    rd(13'h000); rd(13'h048); rd(13'h04C); rd(13'h050); rd(13'h058);
    rd(13'h3F8); rd(13'h3FC); rd(13'h1000);
    in_reset_phase = 0;
    // R2: configuration fields
    wr(13'h04C, 32'hDEAD_BEEF); rd(13'h04C);
    wr(13'h050, 32'hABCD_0600); rd(13'h050);
    wr(13'h058, 32'h0018_0800); rd(13'h058);
    // R5: modes
    wr(13'h048, 32'h0000_0030); rd(13'h048);
    wr(13'h048, 32'h0000_0020); rd(13'h048);
    wr(13'h048, 32'h0000_0030);
    // R3: launch while idle, pulse for one cycle
    wr(13'h000, 32'h0000_0003); idle(2); rd(13'h000);
    // R4: launch while busy ignored
    wr(13'h000, 32'h0000_0000);
    eng_busy = 1;
    wr(13'h000, 32'h0000_0003); idle(1); rd(13'h000);
    // R9: grant held while busy gives nothing
    wr(13'h048, 32'h0000_0130); rd(13'h1004); rd(13'h1FFC);
    eng_busy = 0; tick();
    // R6/R7/R8: events and interrupt
    wr(13'h3F8, 32'h0000_0002); rd(13'h3F8);
    eng_ready = 1; tick(); eng_ready = 0; idle(1); rd(13'h3FC);
    eng_done = 1; tick(); eng_done = 0; idle(1); rd(13'h3FC);
    wr(13'h3FC, 32'h0000_0004); rd(13'h3FC);
    wr(13'h3F8, 32'h0000_0004);
    // R6: set wins over a clearing write in the same cycle
    eng_ready = 1; eng_done = 1; wr(13'h3FC, 32'h0000_0006);
    eng_ready = 0; eng_done = 0; rd(13'h3FC);
    eng_done = 1; wr(13'h3FC, 32'h0000_0006); eng_done = 0; rd(13'h3FC);
    wr(13'h3FC, 32'h0000_0006); rd(13'h3FC);
    // R9: grant with engine idle, window reads and ignored writes
    wr(13'h000, 32'h0); wr(13'h048, 32'h0000_0100);
    rd(13'h1000); rd(13'h1234); rd(13'h1FFC);
    wr(13'h1008, 32'hFFFF_FFFF); rd(13'h1008); rd(13'h048);
    eng_busy = 1; rd(13'h1008); eng_busy = 0;
    wr(13'h048, 32'h0); rd(13'h1008);
    // R10: unmapped and unaligned addresses
    wr(13'h044, 32'hFFFF_FFFF); rd(13'h044);
    wr(13'h04E, 32'h1111_1111); rd(13'h04E); rd(13'h04C);
    wr(13'h100, 32'h0000_0003); rd(13'h100); rd(13'h002); rd(13'h000);
    bus_valid = 0; bus_addr = 13'h04C; tick();
    bus_valid = 1; bus_we = 1; bus_addr = 13'h04C; bus_wdata = 32'h1234_5678; tick();
    bus_valid = 0; bus_we = 0; idle(2);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule